// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break and Idle-Timeout Detection

This block turns an oversampled asynchronous serial line into characters. On each oversample tick it watches the line. It confirms a start bit at mid-bit and samples every later bit at its centre. It then rebuilds a character of 5 to 8 data bits, with an optional parity bit and one or two stop bits. Each complete character is handed to a downstream FIFO through a one-cycle strobe. The FIFO itself lives outside this block.

Alongside reception the block does five things:

- It checks parity and stop bits.
- It recognises a line held low for longer than a whole frame as a break.
- It keeps the received ninth bit for software.
- It counts idle character times while unread data waits in the FIFO.
- It drives a request-to-send output from the FIFO occupancy against a threshold, with a selectable polarity.

The error and event flags are sticky. Software clears them by writing ones.

Top module: `uart_rx_core`

## Requirements
- R1: Data bits arrive LSB first. `cfg_size` selects the character length (0 = 5, 1 = 6, 2 = 7, 3 = 8 bits). `rx_data` holds the character right-aligned with the unused upper bits zero. `rx_valid` is high for exactly one clock after each accepted character.
- R2: After a falling edge, a start bit is accepted only if the line is still low `OSR/2` ticks later. Otherwise the receiver returns to idle and produces no character. `rx_busy` is high from start detection until the receiver is idle again.
- R3: When `cfg_par_en` is 1, the bit after the data is checked against `cfg_par_mode`. The modes are 0 = even, 1 = odd, 2 = always 1, and 3 = always 0. A mismatch sets flag bit 1, and the character is still delivered.
- R4: `par_bit` is updated with every delivered character. It equals the received parity bit when `cfg_size` = 3 and parity is enabled, and is 0 in every other case.
- R5: If the first stop bit is sampled as 0 and the frame is not a break, flag bit 0 (frame error) is set and the character is still delivered.
- R6: If the start, data, parity and all stop samples are 0 and the line is still 0 one bit time later, a break is recognised. `brk_stat` and flag bit 3 are set, no character is delivered, and the receiver waits for the line to return high.
- R7: `flags` are sticky: bit 0 frame, bit 1 parity, bit 2 overrun, bit 3 break, bit 4 timeout. A 1 in `fl_clr` clears the matching bit, and a new event in the same cycle wins. `brk_stat` is cleared by `stat_rd`.
- R8: If a character completes while `fifo_full` is 1, the character is dropped and flag bit 2 (overrun) is set.
- R9: While `fifo_empty` is 0, a counter counts character times. Each character time is (1 + data + parity + stop bits) × `OSR` ticks. When the count reaches a nonzero `cfg_to_chars`, flag bit 4 is set. The count restarts on `fifo_rd` and on each completed character, and it is held at zero while `fifo_empty` is 1.
- R10: The `rts` output is registered. Its request is withdrawn while `fifo_level` ≥ `cfg_rts_lvl`. With `cfg_flow_pol` = 1 the output is active high (withdrawn = 0); with 0 it is active low (withdrawn = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversample tick enable |
| rxd | input | 1 | Serial line, synchronous to clk |
| cfg_size | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_to_chars | input | TO_W | Idle timeout in character times, 0 disables |
| cfg_rts_lvl | input | LVL_W | FIFO level that withdraws the request |
| cfg_flow_pol | input | 1 | 1 = request active high |
| fifo_full | input | 1 | Downstream FIFO is full |
| fifo_empty | input | 1 | Downstream FIFO is empty |
| fifo_rd | input | 1 | FIFO read pulse |
| fifo_level | input | LVL_W | FIFO occupancy |
| stat_rd | input | 1 | Status read pulse, clears brk_stat |
| fl_clr | input | 5 | Write-one-to-clear for flags |
| rx_valid | output | 1 | Character strobe |
| rx_data | output | 8 | Received character |
| par_bit | output | 1 | Received ninth bit |
| rx_busy | output | 1 | Reception in progress |
| brk_stat | output | 1 | Break status |
| flags | output | 5 | Sticky event flags |
| rts | output | 1 | Request-to-send output |

## Verification
The bench builds the block with `OSR` = 8 and keeps `tick` high every clock, so one bit time is eight clocks. This keeps the following within a few thousand cycles:

- a full 14-bit-time break;
- the two-character-time timeout window;
- a restart of that window.

`TO_W` and `LVL_W` stay at their defaults, so the 8-bit timeout count and the 6-bit threshold compare are exercised at full width.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OSR   = 16,
  parameter int TO_W  = 8,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic [1:0]       cfg_size,
  input  logic             cfg_par_en,
  input  logic [1:0]       cfg_par_mode,
  input  logic             cfg_two_stop,
  input  logic [TO_W-1:0]  cfg_to_chars,
  input  logic [LVL_W-1:0] cfg_rts_lvl,
  input  logic             cfg_flow_pol,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             fifo_rd,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             stat_rd,
  input  logic [4:0]       fl_clr,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             par_bit,
  output logic             rx_busy,
  output logic             brk_stat,
  output logic [4:0]       flags,
  output logic             rts
);
  localparam int HALF = OSR / 2;
  localparam int OS_W = $clog2(OSR);
  localparam int CT_W = $clog2(12 * OSR + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_WAIT} st_t;
  st_t st;

  logic [OS_W-1:0] os;
  logic [2:0]      idx;
  logic [7:0]      shreg;
  logic            pbit_r, zero_r;
  logic [1:0]      brk_left;
  logic [CT_W-1:0] tk;
  logic [TO_W-1:0] ch;

  wire samp = tick && (os == OS_W'(OSR - 1));
  wire half = tick && (os == OS_W'(HALF - 1));
  wire [2:0] last_idx = 3'(cfg_size) + 3'd4;
  wire [3:0] frame_bits = 4'd6 + 4'(cfg_size) + 4'(cfg_par_en) + (cfg_two_stop ? 4'd2 : 4'd1);
  wire [CT_W-1:0] char_ticks = CT_W'(frame_bits) * CT_W'(OSR);

  logic exp_par;
  always_comb
    case (cfg_par_mode)
      2'd0:    exp_par = ^shreg;
      2'd1:    exp_par = ~^shreg;
      2'd2:    exp_par = 1'b1;
      default: exp_par = 1'b0;
    endcase

  wire stop_ok   = (st == S_STOP) && samp && rxd;
  wire char_done = ((st == S_STOP) && samp && (rxd || !zero_r)) || ((st == S_BRK) && samp && rxd);
  wire brk_det   = (st == S_BRK) && samp && !rxd && (brk_left == 2'd1);
  wire par_err   = char_done && cfg_par_en && (pbit_r != exp_par);
  wire to_arm    = !fifo_empty && !fifo_rd && !char_done;
  wire to_hit    = to_arm && tick && (ch != cfg_to_chars) && (tk == char_ticks - 1'b1)
                   && (ch + 1'b1 == cfg_to_chars);
  wire [4:0] set_v = {to_hit, brk_det, char_done && fifo_full, par_err, char_done && !stop_ok};

  assign rx_busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; os <= '0; idx <= '0; shreg <= '0;
      pbit_r <= 1'b0; zero_r <= 1'b1; brk_left <= '0;
    end else begin
      if (tick && st != S_IDLE && st != S_WAIT)
        os <= ((st == S_START) ? half : samp) ? '0 : os + 1'b1;
      case (st)
        S_IDLE: if (tick && !rxd) begin
          st <= S_START; os <= '0; idx <= '0; shreg <= '0; zero_r <= 1'b1;
        end
        S_START: if (half) st <= rxd ? S_IDLE : S_DATA;
        S_DATA: if (samp) begin
          shreg[idx] <= rxd;
          zero_r     <= zero_r && !rxd;
          idx        <= idx + 1'b1;
          if (idx == last_idx) st <= cfg_par_en ? S_PAR : S_STOP;
        end
        S_PAR: if (samp) begin
          pbit_r <= rxd; zero_r <= zero_r && !rxd; st <= S_STOP;
        end
        S_STOP: if (samp) begin
          if (rxd || !zero_r) st <= S_IDLE;
          else begin
            st <= S_BRK; brk_left <= cfg_two_stop ? 2'd2 : 2'd1;
          end
        end
        S_BRK: if (samp) begin
          if (rxd) st <= S_IDLE;
          else if (brk_left == 2'd1) st <= S_WAIT;
          else brk_left <= brk_left - 1'b1;
        end
        default: if (rxd) st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; par_bit <= 1'b0;
      flags <= '0; brk_stat <= 1'b0; rts <= 1'b0;
    end else begin
      rx_valid <= char_done && !fifo_full;
      if (char_done && !fifo_full) begin
        rx_data <= shreg;
        par_bit <= (cfg_size == 2'd3) && cfg_par_en && pbit_r;
      end
      flags    <= (flags & ~fl_clr) | set_v;
      brk_stat <= brk_det || (brk_stat && !stat_rd);
      rts      <= cfg_flow_pol ? (fifo_level < cfg_rts_lvl) : (fifo_level >= cfg_rts_lvl);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tk <= '0; ch <= '0;
    end else if (!to_arm) begin
      tk <= '0; ch <= '0;
    end else if (tick && ch != cfg_to_chars) begin
      if (tk == char_ticks - 1'b1) begin
        tk <= '0; ch <= ch + 1'b1;
      end else tk <= tk + 1'b1;
    end
endmodule

module uart_rx_core_chk #(parameter int LVL_W = 6) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_busy,
  input logic             fifo_full,
  input logic [4:0]       flags,
  input logic [4:0]       fl_clr,
  input logic             par_bit,
  input logic [1:0]       cfg_size,
  input logic             cfg_par_en,
  input logic             brk_stat,
  input logic             rts,
  input logic [LVL_W-1:0] fifo_level,
  input logic [LVL_W-1:0] cfg_rts_lvl,
  input logic             cfg_flow_pol
);
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_valid_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_busy));
  p_ninth_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !$past(cfg_size == 2'd3 && cfg_par_en)) |-> !par_bit);
  p_break_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_stat) |-> !rx_valid);
  p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~fl_clr)) == $past(flags & ~fl_clr)));
  p_drop_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(fifo_full));
  p_rts_withdrawn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fifo_level >= cfg_rts_lvl) |-> (rts == !$past(cfg_flow_pol)));
endmodule

bind uart_rx_core uart_rx_core_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_busy(rx_busy),
  .fifo_full(fifo_full), .flags(flags), .fl_clr(fl_clr), .par_bit(par_bit),
  .cfg_size(cfg_size), .cfg_par_en(cfg_par_en), .brk_stat(brk_stat), .rts(rts),
  .fifo_level(fifo_level), .cfg_rts_lvl(cfg_rts_lvl), .cfg_flow_pol(cfg_flow_pol)
);

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
  localparam int CLK_PERIOD = 10;
  localparam int OSR_TB = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1;
  logic [1:0] cfg_size = 2'd3, cfg_par_mode = 2'd0;
  logic cfg_par_en = 1'b0, cfg_two_stop = 1'b0, cfg_flow_pol = 1'b0;
  logic [7:0] cfg_to_chars = 8'd0;
  logic [5:0] cfg_rts_lvl = 6'd10, fifo_level = 6'd0;
  logic fifo_full = 1'b0, fifo_empty = 1'b1, fifo_rd = 1'b0, stat_rd = 1'b0;
  logic [4:0] fl_clr = 5'd0;
  logic rx_valid, par_bit, rx_busy, brk_stat, rts;
  logic [7:0] rx_data;
  logic [4:0] flags;

  int checks = 0, failures = 0, got_n = 0;
  logic [7:0] got_d = 8'd0;
  logic got_p = 1'b0;

  uart_rx_core #(.OSR(OSR_TB)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rx_valid) begin
    got_n++; got_d = rx_data; got_p = par_bit;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic ref_par(input logic [7:0] d, input logic [1:0] mode);
    case (mode)
      2'd0: return ^d;
      2'd1: return ~^d;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_char(input logic [7:0] d, input int nbits, input bit has_par,
                           input logic pb, input logic stopv);
    rxd = 1'b0; wait_n(OSR_TB);
    for (int i = 0; i < nbits; i++) begin rxd = d[i]; wait_n(OSR_TB); end
    if (has_par) begin rxd = pb; wait_n(OSR_TB); end
    rxd = stopv; wait_n(OSR_TB);
    rxd = 1'b1; wait_n(2 * OSR_TB);
  endtask

  task automatic clear_flags;
    fl_clr = 5'h1F; wait_n(1); fl_clr = 5'h00; wait_n(1);
  endtask

  task automatic t_reset;
    chk(rx_valid == 1'b0, "R1 reset valid", rx_valid, 0);
    chk(flags == 5'd0, "R7 reset flags", flags, 0);
    chk(rx_busy == 1'b0, "R2 reset busy", rx_busy, 0);
    chk(brk_stat == 1'b0, "R6 reset break", brk_stat, 0);
  endtask

  task automatic t_basic;
    int n0;
    cfg_size = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    n0 = got_n;
    send_char(8'hA5, 8, 0, 1'b0, 1'b1);
    chk(got_n == n0 + 1, "R1 one strobe 8N1", got_n - n0, 1);
    chk(got_d == 8'hA5, "R1 data 8N1", got_d, 8'hA5);
    cfg_size = 2'd1; cfg_two_stop = 1'b1;
    send_char(8'h2A, 6, 0, 1'b0, 1'b1);
    chk(got_d == 8'h2A, "R1 data 6-bit two stop", got_d, 8'h2A);
    chk(flags == 5'd0, "R1 clean frames no flags", flags, 0);
    cfg_two_stop = 1'b0;
  endtask

  task automatic t_glitch;
    int n0;
    n0 = got_n;
    rxd = 1'b0; wait_n(1);
    chk(rx_busy == 1'b1, "R2 busy on falling edge", rx_busy, 1);
    wait_n(1); rxd = 1'b1; wait_n(2 * OSR_TB);
    chk(rx_busy == 1'b0, "R2 glitch returns idle", rx_busy, 0);
    chk(got_n == n0, "R2 glitch gives no char", got_n - n0, 0);
  endtask

  task automatic t_parity;
    logic p;
    cfg_size = 2'd0; cfg_par_en = 1'b1; cfg_par_mode = 2'd1;
    p = ref_par(8'h13, 2'd1);
    send_char(8'h13, 5, 1, p, 1'b1);
    chk(flags[1] == 1'b0, "R3 odd parity good", flags[1], 0);
    chk(got_d == 8'h13, "R1 R3 5-bit data", got_d, 8'h13);
    send_char(8'h13, 5, 1, ~p, 1'b1);
    chk(flags[1] == 1'b1, "R3 odd parity error", flags[1], 1);
    chk(got_d == 8'h13, "R3 bad parity still delivered", got_d, 8'h13);
    clear_flags();
  endtask

  task automatic t_ninth;
    cfg_size = 2'd3; cfg_par_en = 1'b1; cfg_par_mode = 2'd0;
    send_char(8'h07, 8, 1, ref_par(8'h07, 2'd0), 1'b1);
    chk(got_p == 1'b1, "R4 ninth bit even", got_p, 1);
    cfg_par_mode = 2'd3;
    send_char(8'h07, 8, 1, 1'b0, 1'b1);
    chk(got_p == 1'b0 && flags[1] == 1'b0, "R4 ninth bit space", got_p, 0);
    cfg_par_mode = 2'd2;
    send_char(8'h07, 8, 1, 1'b1, 1'b1);
    chk(got_p == 1'b1 && flags[1] == 1'b0, "R4 R3 ninth bit mark", got_p, 1);
    cfg_size = 2'd2; cfg_par_mode = 2'd0;
    send_char(8'h07, 7, 1, ref_par(8'h07, 2'd0), 1'b1);
    chk(got_p == 1'b0, "R4 7-bit gives zero", got_p, 0);
    cfg_size = 2'd3; cfg_par_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_frame;
    int n0;
    n0 = got_n;
    send_char(8'h3C, 8, 0, 1'b0, 1'b0);
    chk(flags[0] == 1'b1, "R5 frame error flag", flags[0], 1);
    chk(got_n == n0 + 1 && got_d == 8'h3C, "R5 frame error char delivered", got_d, 8'h3C);
    chk(flags[3] == 1'b0, "R5 not a break", flags[3], 0);
  endtask

  task automatic t_clear;
    fl_clr = 5'b00001; wait_n(1); fl_clr = 5'd0; wait_n(1);
    chk(flags[0] == 1'b0, "R7 write-one clears frame bit", flags[0], 0);
  endtask

  task automatic t_break;
    int n0;
    n0 = got_n;
    rxd = 1'b0; wait_n(14 * OSR_TB);
    chk(brk_stat == 1'b1, "R6 break status", brk_stat, 1);
    chk(flags[3] == 1'b1 && flags[0] == 1'b0, "R6 break flag only", flags, 5'h08);
    chk(got_n == n0, "R6 break gives no char", got_n - n0, 0);
    chk(rx_busy == 1'b1, "R6 waits for line high", rx_busy, 1);
    rxd = 1'b1; wait_n(2);
    chk(rx_busy == 1'b0, "R6 idle after line high", rx_busy, 0);
    stat_rd = 1'b1; wait_n(1); stat_rd = 1'b0; wait_n(1);
    chk(brk_stat == 1'b0, "R7 status read clears break", brk_stat, 0);
    chk(flags[3] == 1'b1, "R7 break flag stays sticky", flags[3], 1);
    clear_flags();
    chk(flags == 5'd0, "R7 all flags cleared", flags, 0);
  endtask

  task automatic t_overrun;
    int n0;
    n0 = got_n; fifo_full = 1'b1;
    send_char(8'h55, 8, 0, 1'b0, 1'b1);
    chk(got_n == n0, "R8 char dropped when full", got_n - n0, 0);
    chk(flags[2] == 1'b1, "R8 overrun flag", flags[2], 1);
    fifo_full = 1'b0; clear_flags();
  endtask

  task automatic pulse_rd;
    fifo_rd = 1'b1; wait_n(1); fifo_rd = 1'b0;
  endtask

  task automatic t_timeout;
    cfg_to_chars = 8'd2; fifo_empty = 1'b0;
    pulse_rd(); wait_n(150);
    chk(flags[4] == 1'b0, "R9 no timeout before two chars", flags[4], 0);
    wait_n(15);
    chk(flags[4] == 1'b1, "R9 timeout after two chars", flags[4], 1);
    clear_flags();
    pulse_rd(); wait_n(120); pulse_rd(); wait_n(150);
    chk(flags[4] == 1'b0, "R9 read restarts count", flags[4], 0);
    wait_n(15);
    chk(flags[4] == 1'b1, "R9 timeout after restart", flags[4], 1);
    fifo_empty = 1'b1; clear_flags(); wait_n(400);
    chk(flags[4] == 1'b0, "R9 not armed when empty", flags[4], 0);
    cfg_to_chars = 8'd0;
  endtask

  task automatic t_rts;
    cfg_rts_lvl = 6'd10; cfg_flow_pol = 1'b0; fifo_level = 6'd9; wait_n(2);
    chk(rts == 1'b0, "R10 low-active asserted below level", rts, 0);
    fifo_level = 6'd10; wait_n(2);
    chk(rts == 1'b1, "R10 low-active withdrawn at level", rts, 1);
    cfg_flow_pol = 1'b1; wait_n(2);
    chk(rts == 1'b0, "R10 high-active withdrawn at level", rts, 0);
    fifo_level = 6'd3; wait_n(2);
    chk(rts == 1'b1, "R10 high-active asserted below level", rts, 1);
    cfg_flow_pol = 1'b0; fifo_level = 6'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_n(3); rst_n = 1'b1; wait_n(2);
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_ninth();
    t_frame();
    t_clear();
    t_break();
    t_overrun();
    t_timeout();
    t_rts();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule